// File: doc/BRIEF.md
# Selectable-Width Frame Pulse Generator

This block produces the 8 kHz frame reference for the serial output side of a TDM switch: a frame pulse, a companion output clock, and a one-cycle frame-start strobe that the output stream serialisers use to align their first bit. It runs from a core clock at twice the output bit-clock rate (32.768 MHz for a 16.384 MHz output clock). That lets the frame pulse sit centred on the frame boundary, with half of it before the boundary and half after. The output clock comes straight from a flop.

Two settings shape the pulse. A width-select bit gives either one output-clock period or two. A format input, copied from whatever format was detected on the incoming frame pulse, sets the polarity: active low or active high. Both settings are captured once per frame, just after the wide pulse would have ended, so a change never cuts or stretches a pulse in flight. A registered enable output is provided for the pad three-state driver.

Frame positions below count core clock cycles, 0 to 4095. Position 0 is the cycle in which `frame_start` is high.

Top module: `frame_pulse_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following cycle shows `frame_start` = 0, `clk_out` = 0, `fp_oe` = 0 and `fp_out` at the inactive level of the current `in_fmt_hi`. Count the first rising edge that samples `rst_n` high as edge 1. `frame_start` then first goes high after edge 4096.
- R2: `frame_start` is high for exactly one core cycle in every 4096, which is 2048 `clk_out` periods or 125 µs at the nominal rate.
- R3: `clk_out` alternates on every core cycle out of reset. It is 0 at even frame positions, including position 0, and 1 at odd positions.
- R4: With the narrow width in force, the pulse is active at positions 4095 and 0 only: two core cycles, one `clk_out` period.
- R5: With the wide width in force, the pulse is active at positions 4094, 4095, 0 and 1: four core cycles, two `clk_out` periods.
- R6: With format 0 in force, the pulse is active at level 0 and idles at 1. With format 1 in force, it is active at 1 and idles at 0.
- R7: `wide_sel` (0 narrow, 1 wide) and `in_fmt_hi` are sampled only at the rising edge that enters position 2. The sampled values govern `fp_out` from position 2 onward. A change at any other time, including in the middle of a pulse, leaves the current pulse unchanged.
- R8: `fp_oe` equals `out_en` sampled at the previous rising edge, and is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the output bit-clock rate |
| rst_n | input | 1 | Synchronous reset, active low |
| in_fmt_hi | input | 1 | Detected input frame format: 0 active-low pulse, 1 active-high pulse |
| wide_sel | input | 1 | Control-register width bit: 0 one period, 1 two periods |
| out_en | input | 1 | Output drive enable request |
| fp_out | output | 1 | Frame pulse output |
| clk_out | output | 1 | Companion output clock, half the core rate |
| frame_start | output | 1 | One-cycle strobe at frame position 0 |
| fp_oe | output | 1 | Registered three-state enable for the frame pulse pad |

## Verification
The pulse is exercised in all four combinations of width and polarity. Each one is checked for exact edge placement around `frame_start` and for the total active count over a whole frame. Together these separate a pulse that is off-centre from one of the wrong length. The width bit and the format input are each changed deliberately one cycle before and during a pulse in progress. This separates correct capture at position 2 from immediate application, which would be seen as a truncated, stretched or inverted pulse. A reset in the middle of a frame under the active-high format then shows that the idle level follows the format, and that the frame counter restarts from the beginning.

// File: rtl/fpg_pkg.sv
// Package: shared types for the frame pulse generator.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package fpg_pkg;

    // Per-frame configuration captured by fpg_cfg_latch.
    typedef struct packed {
        logic wide;   // 1: two-period pulse, 0: one-period pulse
        logic hi;     // 1: active-high pulse, 0: active-low pulse
    } fpg_cfg_t;

endpackage

// File: rtl/fpg_timebase.sv
// Module: frame position counter.
// Counts core cycles 0 .. FRAME_CYC-1 and wraps. Exposes the next
// position so that downstream registers can line up with the counter.
// Assumes FRAME_CYC >= 4 and FRAME_CYC fits in POS_W bits.
module fpg_timebase #(
    parameter int FRAME_CYC = 4096,
    parameter int POS_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos_nxt_o
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_CYC - 1);

    logic [POS_W-1:0] pos_q;

    // Next position: wraps from the last position back to zero.
    always_comb begin
        if (!rst_n)
            pos_nxt_o = '0;
        else if (pos_q == LAST_POS)
            pos_nxt_o = '0;
        else
            pos_nxt_o = pos_q + POS_W'(1);
    end

    // Position register: cleared by reset.
    always_ff @(posedge clk) begin
        pos_q <= pos_nxt_o;
    end

    // The counter returns to zero after its last position.
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == LAST_POS) |=> (pos_q == '0));

    // Below the last position, the counter moves up by exactly one.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != LAST_POS) |=> (pos_q == $past(pos_q) + POS_W'(1)));

endmodule

// File: rtl/fpg_cfg_latch.sv
// Module: once-per-frame capture of the width and format settings.
// Captures the settings on the edge that enters position LATCH_POS,
// which lies just after the widest pulse has ended. The pulse in
// progress therefore always finishes with the settings it began with.
// In reset the width returns to narrow and the format follows the input
// live, so that the idle level during reset is already correct.
module fpg_cfg_latch
    import fpg_pkg::*;
#(
    parameter int POS_W     = 12,
    parameter int LATCH_POS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_nxt_i,
    input  logic             wide_i,
    input  logic             hi_i,
    output fpg_cfg_t         cfg_q_o,
    output fpg_cfg_t         cfg_nxt_o
);

    logic lat;

    // Capture strobe: true on the edge that enters the capture position.
    assign lat = (pos_nxt_i == POS_W'(LATCH_POS));

    // Next configuration: reset default, fresh capture, or hold.
    always_comb begin
        if (!rst_n) begin
            cfg_nxt_o.wide = 1'b0;
            cfg_nxt_o.hi   = hi_i;
        end else if (lat) begin
            cfg_nxt_o.wide = wide_i;
            cfg_nxt_o.hi   = hi_i;
        end else begin
            cfg_nxt_o = cfg_q_o;
        end
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        cfg_q_o <= cfg_nxt_o;
    end

    // Outside the capture point, input changes never reach the settings.
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lat |=> (cfg_q_o == $past(cfg_q_o)));

endmodule

// File: rtl/fpg_shaper.sv
// Module: output shaping for the frame pulse, output clock and strobe.
// All outputs are registered from the next frame position and the next
// configuration, so each output matches the position held in the
// counter and carries no decode glitches.
// The pulse sits around the wrap: K cycles before position 0 and K
// cycles from position 0 on, where K is the width in output periods.
// Assumes WIDE_PER >= NARROW_PER >= 1 and 2*WIDE_PER < FRAME_CYC.
module fpg_shaper
    import fpg_pkg::*;
#(
    parameter int FRAME_CYC  = 4096,
    parameter int POS_W      = 12,
    parameter int NARROW_PER = 1,
    parameter int WIDE_PER   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_nxt_i,
    input  fpg_cfg_t         cfg_nxt_i,
    input  fpg_cfg_t         cfg_q_i,
    output logic             fp_o,
    output logic             fs_o,
    output logic             ck_o
);

    localparam logic [POS_W-1:0] N_LO = POS_W'(FRAME_CYC - NARROW_PER);
    localparam logic [POS_W-1:0] N_HI = POS_W'(NARROW_PER);
    localparam logic [POS_W-1:0] W_LO = POS_W'(FRAME_CYC - WIDE_PER);
    localparam logic [POS_W-1:0] W_HI = POS_W'(WIDE_PER);

    logic in_narrow;
    logic in_wide;
    logic act;

    // Window decode for the narrow pulse.
    assign in_narrow = (pos_nxt_i >= N_LO) || (pos_nxt_i < N_HI);

    // Window decode for the wide pulse; shared when both widths coincide.
    generate
        if (WIDE_PER == NARROW_PER) begin : g_same_width
            assign in_wide = in_narrow;
        end else begin : g_own_width
            assign in_wide = (pos_nxt_i >= W_LO) || (pos_nxt_i < W_HI);
        end
    endgenerate

    // Active window chosen by the width setting.
    assign act = cfg_nxt_i.wide ? in_wide : in_narrow;

    // Output registers: idle level in reset, else shaped from next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_o <= ~cfg_nxt_i.hi;
            fs_o <= 1'b0;
            ck_o <= 1'b0;
        end else begin
            fp_o <= cfg_nxt_i.hi ? act : ~act;
            fs_o <= (pos_nxt_i == '0);
            ck_o <= pos_nxt_i[0];
        end
    end

    // The frame-start strobe never lasts longer than one cycle.
    assert_fs_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |=> !fs_o);

    // The frame starts on the low half of the output clock.
    assert_fs_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |-> !ck_o);

    // Out of reset, the output clock changes level on every core cycle.
    assert_clk_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ck_o != $past(ck_o)));

    // The pulse is active at frame start, whatever width is in force.
    assert_fs_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |-> (fp_o == cfg_q_i.hi));

endmodule

// File: rtl/frame_pulse_gen.sv
// Module: top of the selectable-width frame pulse generator.
// Ties together the frame counter, the per-frame settings capture and
// the output shaper, and registers the pad enable.
// Assumes clk runs at twice the output bit-clock rate, and that
// FRAME_PER is the number of output-clock periods in one frame.
module frame_pulse_gen #(
    parameter int FRAME_PER  = 2048,
    parameter int NARROW_PER = 1,
    parameter int WIDE_PER   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_fmt_hi,
    input  logic wide_sel,
    input  logic out_en,
    output logic fp_out,
    output logic clk_out,
    output logic frame_start,
    output logic fp_oe
);

    import fpg_pkg::*;

    localparam int FRAME_CYC = 2 * FRAME_PER;
    localparam int POS_W     = $clog2(FRAME_CYC);
    localparam int LATCH_POS = WIDE_PER;

    logic [POS_W-1:0] pos_nxt;
    fpg_cfg_t         cfg_q;
    fpg_cfg_t         cfg_nxt;

    fpg_timebase #(
        .FRAME_CYC (FRAME_CYC),
        .POS_W     (POS_W)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos_nxt_o (pos_nxt)
    );

    fpg_cfg_latch #(
        .POS_W     (POS_W),
        .LATCH_POS (LATCH_POS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos_nxt_i (pos_nxt),
        .wide_i    (wide_sel),
        .hi_i      (in_fmt_hi),
        .cfg_q_o   (cfg_q),
        .cfg_nxt_o (cfg_nxt)
    );

    fpg_shaper #(
        .FRAME_CYC  (FRAME_CYC),
        .POS_W      (POS_W),
        .NARROW_PER (NARROW_PER),
        .WIDE_PER   (WIDE_PER)
    ) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos_nxt_i (pos_nxt),
        .cfg_nxt_i (cfg_nxt),
        .cfg_q_i   (cfg_q),
        .fp_o      (fp_out),
        .fs_o      (frame_start),
        .ck_o      (clk_out)
    );

    // Pad enable register: off in reset, else follows the request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fp_oe <= 1'b0;
        else
            fp_oe <= out_en;
    end

    // A raised request turns the enable on one cycle later.
    assert_oe_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> fp_oe);

    // A dropped request turns the enable off one cycle later.
    assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !fp_oe);

endmodule

// File: tb/frame_pulse_gen_test.sv
// Bench: behavioural frame model compared on every clock, plus directed
// checks of pulse placement, length, period, settings capture and reset.
module frame_pulse_gen_test;

    localparam int FCYC = 4096;

    logic clk = 1'b0;
    logic rst_n;
    logic in_fmt_hi;
    logic wide_sel;
    logic out_en;
    logic fp_out;
    logic clk_out;
    logic frame_start;
    logic fp_oe;

    int n_chk  = 0;
    int n_fail = 0;

    // Behavioural model state.
    int m_pos     = 0;
    bit m_wide    = 0;
    bit m_hi      = 0;
    bit m_inrst   = 1;
    bit m_oe      = 0;
    bit m_started = 0;

    always #4 clk = ~clk;

    frame_pulse_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_fmt_hi   (in_fmt_hi),
        .wide_sel    (wide_sel),
        .out_en      (out_en),
        .fp_out      (fp_out),
        .clk_out     (clk_out),
        .frame_start (frame_start),
        .fp_oe       (fp_oe)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Model update at each rising edge (inputs change only at falling edges).
    always @(posedge clk) begin
        m_started = 1;
        if (!rst_n) begin
            m_pos = 0; m_wide = 0; m_hi = in_fmt_hi; m_inrst = 1; m_oe = 0;
        end else begin
            m_pos = (m_pos + 1) % FCYC;
            if (m_pos == 2) begin
                m_wide = wide_sel;
                m_hi   = in_fmt_hi;
            end
            m_inrst = 0;
            m_oe    = out_en;
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (m_started) begin
            int  k;
            bit  act;
            k   = m_wide ? 2 : 1;
            act = (m_pos >= FCYC - k) || (m_pos < k);
            if (m_inrst) begin
                chk("R1", fp_out, !m_hi, "fp_out in reset");
                chk("R1", frame_start, 0, "frame_start in reset");
                chk("R1", clk_out, 0, "clk_out in reset");
                chk("R1", fp_oe, 0, "fp_oe in reset");
            end else begin
                chk("R6", fp_out, m_hi ? act : !act, "fp_out level");
                chk("R2", frame_start, m_pos == 0, "frame_start");
                chk("R3", clk_out, m_pos % 2, "clk_out");
                chk("R8", fp_oe, m_oe, "fp_oe");
            end
        end
    end

    // Wait for the falling edge at which frame_start is high (position 0).
    task automatic wait_fs();
        do @(negedge clk); while (frame_start !== 1'b1);
    endtask

    // Check pulse placement for width k and active level hi.
    task automatic shape_chk(input int k, input bit hi, input string tag);
        wait_fs();
        repeat (FCYC - k - 1) @(negedge clk);
        chk(tag, fp_out, !hi, "idle before pulse");
        for (int i = 0; i < 2 * k; i++) begin
            @(negedge clk);
            chk(tag, fp_out, hi, "inside pulse");
        end
        @(negedge clk);
        chk(tag, fp_out, !hi, "idle after pulse");
    endtask

    // Count the active cycles over one whole frame window.
    task automatic len_chk(input int exp, input bit hi, input string tag);
        int cnt;
        cnt = 0;
        wait_fs();
        repeat (100) @(negedge clk);
        for (int i = 0; i < FCYC; i++) begin
            @(negedge clk);
            if (fp_out === hi) cnt++;
        end
        chk(tag, cnt, exp, "active cycles per frame");
    endtask

    initial begin
        rst_n = 0; in_fmt_hi = 0; wide_sel = 0; out_en = 0;
        repeat (3) @(negedge clk);
        chk("R1", fp_out, 1, "reset idle high, format 0");
        chk("R1", fp_oe, 0, "reset enable off");
        rst_n = 1; out_en = 1;

        // Narrow, active low: period, clock phase, placement, length.
        wait_fs();
        begin
            int per;
            per = 0;
            do begin @(negedge clk); per++; end while (frame_start !== 1'b1);
            chk("R2", per, FCYC, "frame_start period");
            chk("R3", clk_out, 0, "clk_out low at frame start");
            @(negedge clk);
            chk("R3", clk_out, 1, "clk_out high after frame start");
        end
        shape_chk(1, 0, "R4");
        len_chk(2, 0, "R4");

        // Width raised one cycle before a narrow pulse: this pulse stays narrow.
        wait_fs();
        repeat (FCYC - 2) @(negedge clk);
        wide_sel = 1;
        @(negedge clk); chk("R7", fp_out, 0, "pos 4095 active");
        @(negedge clk); chk("R7", fp_out, 0, "pos 0 active");
        @(negedge clk); chk("R7", fp_out, 1, "pos 1 idle, pulse not stretched");
        shape_chk(2, 0, "R5");
        len_chk(4, 0, "R5");

        // Format flipped inside a wide active-low pulse: pulse unchanged.
        wait_fs();
        repeat (FCYC - 2) @(negedge clk);
        in_fmt_hi = 1;
        @(negedge clk); chk("R7", fp_out, 0, "pos 4095 keeps low pulse");
        @(negedge clk); chk("R7", fp_out, 0, "pos 0 keeps low pulse");
        @(negedge clk); chk("R7", fp_out, 0, "pos 1 keeps low pulse");
        @(negedge clk); chk("R7", fp_out, 0, "pos 2 new idle level");
        @(negedge clk); chk("R6", fp_out, 0, "active-high idle");
        shape_chk(2, 1, "R6");
        len_chk(4, 1, "R5");

        // Back to narrow under active high.
        wide_sel = 0;
        shape_chk(1, 1, "R4");

        // Enable request follows one cycle later.
        out_en = 0;
        @(negedge clk); chk("R8", fp_oe, 0, "enable dropped");
        out_en = 1;
        @(negedge clk); chk("R8", fp_oe, 1, "enable raised");

        // Reset mid-frame with the active-high format, then restart.
        repeat (500) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk("R1", fp_out, 0, "reset idle low, format 1");
        chk("R1", frame_start, 0, "reset strobe off");
        chk("R1", fp_oe, 0, "reset enable off");
        @(negedge clk);
        rst_n = 1;
        begin
            int edges;
            edges = 0;
            do begin @(negedge clk); edges++; end while (frame_start !== 1'b1);
            chk("R1", edges, FCYC, "edges to first frame_start");
        end
        repeat (10) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule